// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock phases of an I2C bus controller from the system clock. It drives SCL low for a low phase, releases it for a high phase, and tells the byte sequencer when each phase begins and when SDA may safely change after SCL has fallen. Two timing modes are supported. The standard mode uses one 9-bit divider `D` and gives a symmetric period of `4 × D` system clocks. The fast mode uses separate half-counts for the low time and the high time, plus an explicit SDA hold count.

The high phase is timed from the moment the bus is actually seen high, through a synchronizer, and not from the moment the block lets go of SCL. A target that holds SCL low therefore stretches the period. If SCL is held low for longer than a set limit (25 ms worth of clocks by default), a timeout strobe is raised. Configuration inputs may change at any time. The block samples them only when a new low phase starts, so a period that is already running is never altered.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted and in the cycle after it, `scl_drive_low` is 0 and all strobes (`low_start`, `high_start`, `hold_done`, `stretch_timeout`) are 0.
- R2: In standard mode (`fast_mode`=0), with `D = {div_hi, div_lo}` (div_hi in the upper 2 bits, 2 ≤ D ≤ 511), SCL is driven low for 2·D cycles and released for 2·D cycles, so the period is 4·D cycles.
- R3: In fast mode (`fast_mode`=1), with FL=`fast_low` and FH=`fast_high` (both at least 2), SCL is driven low for 2·FL cycles and released for 2·FH cycles. The divider inputs have no effect in this mode.
- R4: `hold_done` pulses for one cycle exactly N cycles after `low_start`, where N=`hold_cnt` in fast mode and N=D in standard mode. N must be at least 1 and less than the low-phase length.
- R5: The high-phase count starts only once SCL is seen high. `high_start` pulses 3 cycles after the bus rises, and the next low phase begins H cycles after the bus rises, where H is the programmed high length. A target holding SCL low therefore lengthens the period.
- R6: If SCL stays low for STRETCH_LIMIT cycles after the block releases it, `stretch_timeout` pulses once for that phase. A shorter stretch produces no pulse.
- R7: Configuration changes made during a period take effect only from the next `low_start`.
- R8: While idle, `low_start` pulses in the cycle after `enable` is first seen high. If `enable` is cleared, the running period completes, SCL stays released, and no further `low_start` occurs.
- R9: `low_start` coincides with SCL being driven low. `high_start` and `stretch_timeout` occur only while SCL is released, and no two of them ever pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the SCL generator |
| fast_mode | input | 1 | 1 selects separate high/low/hold counts |
| div_lo | input | 7 | Lower 7 bits of the standard-mode divider |
| div_hi | input | 2 | Upper 2 bits of the standard-mode divider |
| fast_high | input | 7 | Fast-mode high time, in units of two clocks |
| fast_low | input | 7 | Fast-mode low time, in units of two clocks |
| hold_cnt | input | 8 | Fast-mode SDA hold time in clocks |
| scl_in | input | 1 | Level sensed on the SCL wire |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| low_start | output | 1 | One-cycle strobe when a low phase begins |
| high_start | output | 1 | One-cycle strobe when the high count starts |
| hold_done | output | 1 | One-cycle strobe when the SDA hold time has elapsed |
| stretch_timeout | output | 1 | One-cycle strobe when SCL has been held low too long |

## Verification
All outputs are registers, so every strobe and level change appears one cycle after the edge that causes it. The bench samples on the falling edge and counts cycles from the `low_start` it has observed. On that count, the release of SCL is due at 2·D or 2·FL, `hold_done` at N, `high_start` three cycles after the wire is seen high (two synchronizer stages plus the phase register), and the next `low_start` at the low length plus the high length. With an external hold, `high_start` is due 3 cycles after the bench lets go of the wire and the timeout strobe STRETCH_LIMIT cycles after the release point. Every measurement compares these exact cycle numbers with values computed in bench functions, and configuration is applied before the `low_start` that must latch it.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/scl_tgen_cfg.sv
// Selects phase lengths for the active mode; the high-phase reload
// value is captured at each low-phase start so a running period is stable.
module scl_tgen_cfg #(
  parameter int DIV_LO_W = 7,
  parameter int DIV_HI_W = 2,
  parameter int FAST_W   = 7,
  parameter int HOLD_W   = 8,
  parameter int LEN_W    = 10,
  parameter int LEAD     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                fast_mode,
  input  logic [DIV_LO_W-1:0] div_lo,
  input  logic [DIV_HI_W-1:0] div_hi,
  input  logic [FAST_W-1:0]   fast_high,
  input  logic [FAST_W-1:0]   fast_low,
  input  logic [HOLD_W-1:0]   hold_cnt,
  output logic [LEN_W-1:0]    low_len,
  output logic [LEN_W-1:0]    hold_len,
  output logic [LEN_W-1:0]    high_reload
);

  localparam int DIV_W = DIV_LO_W + DIV_HI_W;

  logic [DIV_W-1:0] divider;
  logic [LEN_W-1:0] high_len;
  logic [LEN_W-1:0] lead_c;

  assign divider = {div_hi, div_lo};
  assign lead_c  = LEN_W'(LEAD);

  always_comb begin
    if (fast_mode) begin
      low_len  = LEN_W'({fast_low, 1'b0});
      high_len = LEN_W'({fast_high, 1'b0});
      hold_len = LEN_W'(hold_cnt);
    end else begin
      low_len  = LEN_W'({divider, 1'b0});
      high_len = LEN_W'({divider, 1'b0});
      hold_len = LEN_W'(divider);
    end
  end

  // The synchronizer and phase register already consume LEAD cycles of
  // the released time, so the counter is shortened by that amount.
  always_ff @(posedge clk) begin
    if (rst) begin
      high_reload <= '0;
    end else if (load) begin
      if (high_len > lead_c)
        high_reload <= high_len - lead_c - LEN_W'(1);
      else
        high_reload <= '0;
    end
  end

endmodule

// File: rtl/scl_tgen_sync.sv
// Multi-stage synchronizer for the sensed SCL level; resets to idle-high.
module scl_tgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b1;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/scl_tgen_stretch.sv
// Counts cycles that SCL stays low after release and flags a timeout once.
module scl_tgen_stretch #(
  parameter int LIMIT = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic held_low,
  output logic timeout
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (held_low && cnt != LIM_C) begin
        cnt     <= cnt + CNT_W'(1);
        timeout <= (cnt == LIM_C - CNT_W'(1));
      end
    end
  end

endmodule

// File: rtl/scl_tgen_fsm.sv
// Phase sequencer: low phase, wait for bus high, timed high phase.
module scl_tgen_fsm
  import scl_tgen_pkg::*;
#(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             scl_high,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] hold_len,
  input  logic [LEN_W-1:0] high_reload,
  output logic             load,
  output phase_e           phase,
  output logic             scl_low,
  output logic             low_start,
  output logic             high_start,
  output logic             hold_done
);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] hcnt;

  assign load = enable &&
                ((phase == PH_IDLE) || (phase == PH_HIGH && cnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      hcnt       <= '0;
      scl_low    <= 1'b0;
      low_start  <= 1'b0;
      high_start <= 1'b0;
      hold_done  <= 1'b0;
    end else begin
      low_start  <= 1'b0;
      high_start <= 1'b0;
      hold_done  <= 1'b0;
      if (hcnt != '0) begin
        hcnt      <= hcnt - LEN_W'(1);
        hold_done <= (hcnt == LEN_W'(1));
      end
      if (load) begin
        phase     <= PH_LOW;
        cnt       <= low_len - LEN_W'(1);
        hcnt      <= hold_len;
        scl_low   <= 1'b1;
        low_start <= 1'b1;
      end else begin
        case (phase)
          PH_LOW: begin
            if (cnt == '0) begin
              phase   <= PH_WAIT;
              scl_low <= 1'b0;
            end else begin
              cnt <= cnt - LEN_W'(1);
            end
          end
          PH_WAIT: begin
            if (scl_high) begin
              phase      <= PH_HIGH;
              cnt        <= high_reload;
              high_start <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (cnt != '0) cnt <= cnt - LEN_W'(1);
            else           phase <= PH_IDLE;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tgen_pkg::*;
#(
  parameter int DIV_LO_W      = 7,
  parameter int DIV_HI_W      = 2,
  parameter int FAST_W        = 7,
  parameter int HOLD_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int STRETCH_LIMIT = 500000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                fast_mode,
  input  logic [DIV_LO_W-1:0] div_lo,
  input  logic [DIV_HI_W-1:0] div_hi,
  input  logic [FAST_W-1:0]   fast_high,
  input  logic [FAST_W-1:0]   fast_low,
  input  logic [HOLD_W-1:0]   hold_cnt,
  input  logic                scl_in,
  output logic                scl_drive_low,
  output logic                low_start,
  output logic                high_start,
  output logic                hold_done,
  output logic                stretch_timeout
);

  localparam int DIV_W = DIV_LO_W + DIV_HI_W;
  localparam int LEN_W = imax(imax(DIV_W, FAST_W) + 1, HOLD_W);
  localparam int LEAD  = SYNC_STAGES + 1;

  logic             load;
  logic             scl_sync;
  phase_e           phase;
  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] hold_len;
  logic [LEN_W-1:0] high_reload;

  scl_tgen_cfg #(
    .DIV_LO_W(DIV_LO_W), .DIV_HI_W(DIV_HI_W), .FAST_W(FAST_W),
    .HOLD_W(HOLD_W), .LEN_W(LEN_W), .LEAD(LEAD)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(load), .fast_mode(fast_mode),
    .div_lo(div_lo), .div_hi(div_hi), .fast_high(fast_high),
    .fast_low(fast_low), .hold_cnt(hold_cnt),
    .low_len(low_len), .hold_len(hold_len), .high_reload(high_reload)
  );

  scl_tgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(scl_in), .dout(scl_sync)
  );

  scl_tgen_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .scl_high(scl_sync),
    .low_len(low_len), .hold_len(hold_len), .high_reload(high_reload),
    .load(load), .phase(phase), .scl_low(scl_drive_low),
    .low_start(low_start), .high_start(high_start), .hold_done(hold_done)
  );

  scl_tgen_stretch #(.LIMIT(STRETCH_LIMIT)) u_stretch (
    .clk(clk), .rst(rst),
    .clear(phase != PH_WAIT),
    .held_low(phase == PH_WAIT && !scl_sync),
    .timeout(stretch_timeout)
  );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst,
  input logic scl_drive_low,
  input logic low_start,
  input logic high_start,
  input logic hold_done,
  input logic stretch_timeout
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!scl_drive_low && !low_start && !high_start && !hold_done && !stretch_timeout));

  p_low_start_pulls_r9: assert property (@(posedge clk) disable iff (rst)
    low_start |-> scl_drive_low);

  p_fall_has_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_drive_low) |-> low_start);

  p_strobes_apart_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({low_start, high_start, stretch_timeout}));

  p_high_released_r5: assert property (@(posedge clk) disable iff (rst)
    high_start |-> !scl_drive_low);

  p_hold_in_low_r4: assert property (@(posedge clk) disable iff (rst)
    hold_done |-> scl_drive_low);

  p_timeout_released_r6: assert property (@(posedge clk) disable iff (rst)
    stretch_timeout |-> !scl_drive_low);

  p_timeout_once_r6: assert property (@(posedge clk) disable iff (rst)
    stretch_timeout |=> !stretch_timeout);

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk(clk), .rst(rst), .scl_drive_low(scl_drive_low),
  .low_start(low_start), .high_start(high_start),
  .hold_done(hold_done), .stretch_timeout(stretch_timeout)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 40;
  localparam int LAT        = 3;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       fast_mode = 1'b0;
  logic [6:0] div_lo = 7'd2;
  logic [1:0] div_hi = 2'd0;
  logic [6:0] fast_high = 7'd2;
  logic [6:0] fast_low = 7'd2;
  logic [7:0] hold_cnt = 8'd1;
  logic       ext_hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, low_start, high_start, hold_done, stretch_timeout;

  int tests = 0;
  int fails = 0;

  logic       nx_fast, nx_en;
  logic [8:0] nx_div;
  logic [6:0] nx_fh, nx_fl;
  logic [7:0] nx_hold;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_in = ~scl_drive_low & ~ext_hold;

  scl_timing_gen #(.STRETCH_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .enable(enable), .fast_mode(fast_mode),
    .div_lo(div_lo), .div_hi(div_hi), .fast_high(fast_high),
    .fast_low(fast_low), .hold_cnt(hold_cnt), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .low_start(low_start),
    .high_start(high_start), .hold_done(hold_done),
    .stretch_timeout(stretch_timeout)
  );

  function automatic int exp_low(input logic f, input int d, input int fl);
    return f ? 2 * fl : 2 * d;
  endfunction
  function automatic int exp_high(input logic f, input int d, input int fh);
    return f ? 2 * fh : 2 * d;
  endfunction
  function automatic int exp_hold(input logic f, input int d, input int h);
    return f ? h : d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic f, input int d, input int fl, input int fh, input int h);
    fast_mode = f;
    {div_hi, div_lo} = 9'(d);
    fast_low = 7'(fl);
    fast_high = 7'(fh);
    hold_cnt = 8'(h);
  endtask

  task automatic apply_nx();
    set_cfg(nx_fast, int'(nx_div), int'(nx_fl), int'(nx_fh), int'(nx_hold));
    enable = nx_en;
  endtask

  task automatic wait_start();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (low_start) break;
    end
  endtask

  // Called at a falling edge where low_start was seen (t = 0).
  task automatic measure(input int swap_at, input int rel_at, input int max_t,
                         output int lo, output int per, output int hd,
                         output int hs, output int to, output int nto,
                         output bit got);
    int t;
    t = 0; lo = -1; hd = -1; hs = -1; to = -1; nto = 0; got = 0;
    while (t < max_t) begin
      @(negedge clk);
      t++;
      if (t == swap_at) apply_nx();
      if (t == rel_at) ext_hold = 1'b0;
      if (hold_done && hd < 0) hd = t;
      if (!scl_drive_low && lo < 0) lo = t;
      if (high_start && hs < 0) hs = t;
      if (stretch_timeout) begin
        nto++;
        if (to < 0) to = t;
      end
      if (low_start) begin
        got = 1;
        break;
      end
    end
    per = t;
  endtask

  task automatic check_period(input string req, input logic f, input int d,
                              input int fl, input int fh, input int h);
    int lo, per, hd, hs, to, nto;
    bit got;
    int el, eh;
    el = exp_low(f, d, fl);
    eh = exp_high(f, d, fh);
    measure(-1, -1, 4000, lo, per, hd, hs, to, nto, got);
    check({req, " low length"}, lo, el);
    check({req, " period"}, per, el + eh);
    check({"R5 high_start ", req}, hs, el + LAT);
    check({"R4 hold ", req}, hd, exp_hold(f, d, h));
    check({"R9 next low_start ", req}, int'(got), 1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lo, per, hd, hs, to, nto;
    bit got;
    void'($urandom(32'd1234));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 scl during reset", int'(scl_drive_low), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 scl after reset", int'(scl_drive_low), 0);
    check("R1 strobes after reset",
          int'({low_start, high_start, hold_done, stretch_timeout}), 0);
    repeat (3) @(negedge clk);
    check("R8 idle without enable", int'(scl_drive_low | low_start), 0);

    // R8: start from idle; R2 minimum divider
    set_cfg(1'b0, 2, 2, 2, 1);
    enable = 1'b1;
    @(negedge clk);
    check("R8 low_start after enable", int'(low_start), 1);
    check_period("R2 D=2", 1'b0, 2, 2, 2, 1);

    // R2: maximum divider
    set_cfg(1'b0, 511, 5, 5, 1);
    wait_start();
    check_period("R2 D=511", 1'b0, 511, 5, 5, 1);

    // R3: fast mode, 32/22 clocks with hold 7; divider set to a conflicting value
    set_cfg(1'b1, 77, 16, 11, 7);
    wait_start();
    check_period("R3 fast 16/11", 1'b1, 77, 16, 11, 7);
    set_cfg(1'b1, 300, 8, 5, 7);
    wait_start();
    check_period("R3 fast 8/5", 1'b1, 300, 8, 5, 7);

    // Random configurations
    for (int i = 0; i < 12; i++) begin
      logic f;
      int d, fl, fh, h, hmax;
      f  = 1'($urandom_range(0, 1));
      d  = $urandom_range(2, 300);
      fl = $urandom_range(2, 127);
      fh = $urandom_range(2, 127);
      hmax = (2 * fl - 1 < 255) ? 2 * fl - 1 : 255;
      h  = $urandom_range(1, hmax);
      set_cfg(f, d, fl, fh, h);
      wait_start();
      check_period(f ? "R3 random" : "R2 random", f, d, fl, fh, h);
    end

    // R5: short stretch, no timeout (fast 10/10)
    set_cfg(1'b1, 2, 5, 5, 3);
    wait_start();
    ext_hold = 1'b1;
    measure(-1, 10 + 10, 4000, lo, per, hd, hs, to, nto, got);
    check("R5 stretched high_start", hs, 20 + LAT);
    check("R5 stretched period", per, 20 + 10);
    check("R6 no timeout for short stretch", nto, 0);

    // R6: long stretch raises one timeout
    ext_hold = 1'b1;
    measure(-1, 10 + 60, 4000, lo, per, hd, hs, to, nto, got);
    check("R6 timeout time", to, 10 + LIMIT);
    check("R6 timeout count", nto, 1);
    check("R5 period after long stretch", per, 70 + 10);

    // R7: change mid-period; current period keeps old values
    nx_fast = 1'b0; nx_div = 9'd6; nx_fl = 7'd5; nx_fh = 7'd5; nx_hold = 8'd3; nx_en = 1'b1;
    measure(2, -1, 4000, lo, per, hd, hs, to, nto, got);
    check("R7 old low kept", lo, 10);
    check("R7 old period kept", per, 20);
    check("R7 old hold kept", hd, 3);
    measure(-1, -1, 4000, lo, per, hd, hs, to, nto, got);
    check("R7 new low", lo, 12);
    check("R7 new period", per, 24);
    check("R7 new hold", hd, 6);

    // R8: disable mid-period; the period completes and stays released
    nx_fast = 1'b0; nx_div = 9'd6; nx_fl = 7'd5; nx_fh = 7'd5; nx_hold = 8'd3; nx_en = 1'b0;
    measure(3, -1, 200, lo, per, hd, hs, to, nto, got);
    check("R8 low completes after disable", lo, 12);
    check("R8 high_start after disable", hs, 12 + LAT);
    check("R8 no further low_start", int'(got), 0);
    check("R8 scl released when stopped", int'(scl_drive_low), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule